// File: doc/BRIEF.md
# TDM Channel Extractor

This block picks one channel out of a time-division multiplexed sample stream. The stream carries up to eight channels, one per clock, and a frame strobe one clock wide marks the clock that carries channel 0. The block needs no wide data multiplexer. It delays the frame strobe by the programmed channel number and uses the delayed strobe as the load enable of a capture register. Channel 0 is captured on the strobe clock itself. Channel n is captured n clocks later.

A second register loads the captured sample on the next frame strobe. The delay applied at capture is therefore undone at this point. Whatever channel is chosen, the sample leaves the block one clock after the strobe that follows its own frame, together with a one-clock valid pulse. The block flags a protocol error when a new strobe arrives before the previous frame's delayed capture has happened. In that case the newer strobe replaces the older one: the pending capture is dropped and the new frame is handled normally.

Top module: `tdm_chan_extract`

## Requirements
- R1: While reset is held, and in the first clock after it, `dout`, `dout_vld` and `proto_err` are all 0.
- R2: `chan_sel` is sampled on the strobe clock. With value n (0 to 7), the sample captured is the `din` value present n clocks after the strobe clock, where n = 0 means the strobe clock itself.
- R3: The sample captured in a frame appears on `dout` one clock after the next frame strobe. This is the same latency for every channel number.
- R4: `dout_vld` is high for exactly one clock, one clock after a strobe, and only if a capture took place since the strobe before it. The first strobe after reset therefore gives no valid pulse.
- R5: `dout` changes only in the clock where `dout_vld` is high. Otherwise it holds its value through idle clocks and through strobes that have nothing captured.
- R6: Changing `chan_sel` on clocks other than the strobe clock does not change which sample the current frame captures.
- R7: `proto_err` pulses for one clock, one clock after a strobe, when that strobe arrives while a capture for a nonzero channel of the previous frame is still pending.
- R8: A strobe that arrives while a capture is still pending cancels it. That frame yields no sample, and the new frame is captured according to the newly sampled `chan_sel`.
- R9: Frames shorter than eight clocks work as long as the chosen channel lies inside the frame. This includes a strobe on every clock with channel 0, which yields a valid sample on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Multiplexed sample bus, one channel per clock |
| frame_stb | input | 1 | One-clock strobe aligned with channel 0 |
| chan_sel | input | SEL_W | Channel number to extract, sampled on the strobe clock |
| dout | output | DATA_W | Realigned extracted sample |
| dout_vld | output | 1 | One-clock pulse when dout is updated |
| proto_err | output | 1 | One-clock pulse for a strobe that arrived while a capture was pending |

## Verification
The hardest case to reach is a strobe that lands while the delayed capture of the previous frame is still pending. This requires a frame that is shorter than the selected channel number and longer than zero, and in some cases a second strobe on the exact clock the delayed capture would have fired. The stimulus produces this situation deliberately, with short frames that carry high channel numbers and with strobes spaced one clock apart. It then runs long random sequences in which frame length, channel number, idle gaps and mid-frame changes of `chan_sel` all vary. A behavioural model that counts clocks since the last strobe predicts every output on every clock, including the cancelled frames.

// File: rtl/tdm_ext_pkg.sv
package tdm_ext_pkg;
  localparam int unsigned TDM_MAX_CH_LIMIT = 64;

  function automatic int unsigned tdm_sel_bits(input int unsigned n_ch);
    int unsigned b;
    b = 1;
    while ((1 << b) < n_ch) b++;
    return b;
  endfunction
endpackage

// File: rtl/tdm_strobe_delay.sv
module tdm_strobe_delay #(
  parameter int unsigned MAX_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_i,
  output logic [MAX_CH-1:0] tap_o
);
  logic [MAX_CH-1:1] stage_q;

  // position 0 is the strobe clock itself
  assign tap_o = {stage_q, 1'b0};

  generate
    for (genvar k = 1; k < MAX_CH; k++) begin : g_stage
      if (k == 1) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[k] <= 1'b0;
          else     stage_q[k] <= stb_i;
        end
      end else begin : g_rest
        // a fresh strobe wipes older pulses so only the newest frame is tracked
        always_ff @(posedge clk) begin
          if (rst)        stage_q[k] <= 1'b0;
          else if (stb_i) stage_q[k] <= 1'b0;
          else            stage_q[k] <= stage_q[k-1];
        end
      end
    end
  endgenerate

  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_q)) else $error("more than one strobe in flight"); // R8
endmodule

// File: rtl/tdm_capture.sv
module tdm_capture #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MAX_CH = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din_i,
  input  logic              stb_i,
  input  logic [SEL_W-1:0]  chan_sel_i,
  input  logic [MAX_CH-1:0] tap_i,
  output logic [DATA_W-1:0] cap_o,
  output logic              fill_o,
  output logic              err_o
);
  logic [SEL_W-1:0] sel_q;
  logic             armed_q;
  logic             hit_now;
  logic             hit_late;
  logic             hit;

  assign hit_now  = stb_i && (chan_sel_i == '0);
  assign hit_late = !stb_i && armed_q && tap_i[sel_q];
  assign hit      = hit_now || hit_late;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      armed_q <= 1'b0;
    end else if (stb_i) begin
      sel_q   <= chan_sel_i;
      armed_q <= (chan_sel_i != '0);
    end else if (hit_late) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      cap_o <= '0;
    else if (hit) cap_o <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst)        fill_o <= 1'b0;
    else if (hit)   fill_o <= 1'b1;
    else if (stb_i) fill_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= stb_i && armed_q;
  end

  AST_ERR_ON_STB: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(stb_i)) else $error("error without strobe"); // R7
  AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stb_i && chan_sel_i != '0) |=> !fill_o) else $error("stale capture kept"); // R4
endmodule

// File: rtl/tdm_realign.sv
module tdm_realign #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] cap_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= stb_i && fill_i;
      if (stb_i && fill_i) dout_o <= cap_i;
    end
  end

  AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> $past(stb_i)) else $error("valid without strobe"); // R4
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> $stable(dout_o)) else $error("output moved off strobe"); // R5
endmodule

// File: rtl/tdm_chan_extract.sv
module tdm_chan_extract
  import tdm_ext_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MAX_CH = 8,
  parameter int unsigned SEL_W  = tdm_sel_bits(MAX_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              frame_stb,
  input  logic [SEL_W-1:0]  chan_sel,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic              proto_err
);
  localparam int unsigned N_TAP = 1 << SEL_W;

  logic [N_TAP-1:0]  tap;
  logic [DATA_W-1:0] cap;
  logic              fill;

  initial begin
    if (MAX_CH < 2 || MAX_CH > TDM_MAX_CH_LIMIT || N_TAP != MAX_CH)
      $error("MAX_CH must be a power of two within limits");
  end

  tdm_strobe_delay #(.MAX_CH(N_TAP)) u_dly (
    .clk   (clk),
    .rst   (rst),
    .stb_i (frame_stb),
    .tap_o (tap)
  );

  tdm_capture #(.DATA_W(DATA_W), .MAX_CH(N_TAP), .SEL_W(SEL_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .din_i      (din),
    .stb_i      (frame_stb),
    .chan_sel_i (chan_sel),
    .tap_i      (tap),
    .cap_o      (cap),
    .fill_o     (fill),
    .err_o      (proto_err)
  );

  tdm_realign #(.DATA_W(DATA_W)) u_rea (
    .clk    (clk),
    .rst    (rst),
    .stb_i  (frame_stb),
    .cap_i  (cap),
    .fill_i (fill),
    .dout_o (dout),
    .vld_o  (dout_vld)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!dout_vld && !proto_err)) else $error("output active after reset"); // R1
endmodule

// File: tb/sim_tdm_chan_extract.sv
module sim_tdm_chan_extract;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic          frame_stb = 1'b0;
  logic [2:0]    chan_sel = '0;
  logic [DW-1:0] dout;
  logic          dout_vld;
  logic          proto_err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  int          m_pos = -1;
  int          m_sel = 0;
  bit          m_armed = 0;
  bit          m_full = 0;
  logic [DW-1:0] m_cap = '0;
  logic [DW-1:0] e_dout = '0;
  bit          e_vld = 0;
  bit          e_err = 0;

  always #4 clk = ~clk;

  tdm_chan_extract u0 (
    .clk(clk), .rst(rst), .din(din), .frame_stb(frame_stb),
    .chan_sel(chan_sel), .dout(dout), .dout_vld(dout_vld), .proto_err(proto_err)
  );

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_pos = -1; m_sel = 0; m_armed = 0; m_full = 0; m_cap = '0;
      e_dout = '0; e_vld = 0; e_err = 0;
    end else begin
      e_vld = 0;
      e_err = 0;
      if (frame_stb) begin
        if (m_full) begin
          e_dout = m_cap;
          e_vld = 1;
        end
        m_full = 0;
        e_err = m_armed;
        m_pos = 0;
        m_sel = int'(chan_sel);
        m_armed = (m_sel != 0);
        if (m_sel == 0) begin
          m_cap = din;
          m_full = 1;
        end
      end else begin
        if (m_pos >= 0) m_pos++;
        if (m_armed && m_pos == m_sel) begin
          m_cap = din;
          m_full = 1;
          m_armed = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      total++;
      if (dout !== e_dout || dout_vld !== e_vld || proto_err !== e_err) begin
        bad++;
        $display("FAIL %s cycle %0d: dout=%h vld=%b err=%b expected dout=%h vld=%b err=%b",
                 cur_req, cycles, dout, dout_vld, proto_err, e_dout, e_vld, e_err);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      finish_run();
    end
  end

  task automatic cyc(input bit s, input int sel);
    @(negedge clk);
    frame_stb = s;
    chan_sel = sel[2:0];
    din = DW'($urandom);
  endtask

  task automatic frame(input int len, input int sel, input bit wobble);
    cyc(1, sel);
    for (int i = 1; i < len; i++) cyc(0, wobble ? int'($urandom_range(0, 7)) : sel);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, int'($urandom_range(0, 7)));
  endtask

  initial begin
    cur_req = "R1";
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(2);

    cur_req = "R4";
    frame(8, 3, 0);
    cur_req = "R2";
    for (int s = 0; s < 8; s++)
      for (int f = 0; f < 3; f++) frame(8, s, 0);
    cur_req = "R3";
    for (int f = 0; f < 20; f++) frame(8, int'($urandom_range(0, 7)), 0);

    cur_req = "R6";
    for (int f = 0; f < 30; f++) frame(8, int'($urandom_range(0, 7)), 1);

    cur_req = "R5";
    for (int f = 0; f < 10; f++) begin
      frame(8, int'($urandom_range(0, 7)), 0);
      idle(int'($urandom_range(1, 9)));
    end
    frame(8, 2, 0);
    idle(30);

    cur_req = "R9";
    for (int f = 0; f < 12; f++) frame(3, f % 3, 0);
    for (int i = 0; i < 20; i++) frame(1, 0, 0);
    for (int f = 0; f < 10; f++) frame(5, 4, 0);

    cur_req = "R7";
    frame(3, 5, 0);
    frame(8, 1, 0);
    frame(2, 7, 0);
    frame(8, 0, 0);
    cur_req = "R8";
    frame(4, 4, 0);
    frame(8, 6, 0);
    frame(1, 3, 0);
    frame(1, 2, 0);
    frame(8, 1, 0);
    frame(8, 0, 0);

    cur_req = "R3";
    for (int f = 0; f < 400; f++) begin
      frame(int'($urandom_range(1, 10)), int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 6)));
    end

    cur_req = "R1";
    @(negedge clk);
    rst = 1'b1;
    frame_stb = 1'b0;
    idle(3);
    rst = 1'b0;
    idle(3);
    cur_req = "R4";
    frame(8, 0, 0);
    frame(8, 0, 0);
    idle(3);
    finish_run();
  end
endmodule